// File: doc/BRIEF.md
# Secure-state user debug enable control register

This block keeps a small control register that grants the lowest privilege level, while it runs in secure state, two debug permissions: taking debug exceptions (invasive) and counting performance events (non-invasive). Software reaches the register through a coprocessor-style access that carries a five-field encoding, a read/write flag and write data. The block compares the encoding with its own address. For a match it applies an ordered permission chain built from the current privilege level, the security state, a hypervisor trap control and a write-lock pin. The chain picks one of three outcomes: the access completes, it is reported as undefined, or it is trapped to the hypervisor level with a fixed syndrome code.

The two stored enable bits are also driven out to the debug and event-counting logic. Both outputs are held inactive whenever the core is in non-secure state. Instruction decode, exception entry and the logic that uses the enables are outside this block.

Top module: `sdbg_ctl_unit`

## Requirements
- R1: An access is matched only when coproc=4'b1111, opc1=3'b000, CRn=4'b0001, CRm=4'b0001 and opc2=3'b001. A request with any other encoding raises no strobe and leaves the stored bits unchanged.
- R2: Stored bit 0 is the invasive enable and drives `en_inv`. Stored bit 1 is the non-invasive enable and drives `en_noninv`. While `ns_state`=0 each output equals its stored bit.
- R3: Bits [31:2] always read as zero, and values written to them are discarded.
- R4: After reset both stored bits are 0 and all strobes, the syndrome and the read data are 0.
- R5: A matched access at privilege level 0 or level 2 (`cur_el` = 0 or 2) is undefined.
- R6: At level 1, a matched access with `hyp_en`=1 and `hyp_trap`=1 is trapped, and `rsp_syndrome` reads 0x03 with the trap strobe. This check takes priority over the security check.
- R7: At level 1 without a trap, the access completes when `ns_state`=0 and is undefined when `ns_state`=1.
- R8: At level 3, a matched read always completes.
- R9: At level 3, a matched write is undefined when `ns_state`=0 and `wr_lock`=1. In every other case it completes.
- R10: While `ns_state`=1, `en_inv` and `en_noninv` are both 0, whatever is stored.
- R11: Each matched request raises exactly one of `rsp_done`, `rsp_undef` or `rsp_trap`, for one cycle, in the cycle after the request. A completed write is visible in the stored bits from that same cycle on.
- R12: `rsp_rdata` holds the stored value alongside `rsp_done` for a completed read and is zero otherwise. `rsp_syndrome` is zero unless `rsp_trap` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset |
| req_vld | input | 1 | Access request valid for one cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_coproc | input | 4 | Encoding field: coprocessor number |
| req_opc1 | input | 3 | Encoding field: first opcode |
| req_crn | input | 4 | Encoding field: primary register |
| req_crm | input | 4 | Encoding field: secondary register |
| req_opc2 | input | 3 | Encoding field: second opcode |
| req_wdata | input | 32 | Write data |
| cur_el | input | 2 | Current privilege level, 0 to 3 |
| ns_state | input | 1 | 1 = core is in non-secure state |
| hyp_en | input | 1 | Hypervisor level is enabled |
| hyp_trap | input | 1 | Hypervisor trap control for this register group |
| wr_lock | input | 1 | Lock pin for writes from level 3 |
| rsp_done | output | 1 | Access completed |
| rsp_undef | output | 1 | Access undefined |
| rsp_trap | output | 1 | Access trapped to hypervisor level |
| rsp_syndrome | output | 6 | Trap syndrome code |
| rsp_rdata | output | 32 | Read data |
| en_inv | output | 1 | Secure level-0 invasive debug enable |
| en_noninv | output | 1 | Secure level-0 event-counting enable |

## Verification
The strobes, syndrome and read data are registered, so each is due exactly one clock after the edge that samples a request. The bench drives a request on a falling edge and checks these results on the next falling edge, which lies after the single register stage. A completed write changes the stored bits at that same edge. The enable outputs are combinational on the stored bits and on the present `ns_state`, so they are checked at the same falling edge against a bench model that is updated only on predicted completions. A directed step then confirms that the strobes have cleared one cycle later.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

  typedef enum logic [1:0] {
    OUT_DONE  = 2'd0,
    OUT_UNDEF = 2'd1,
    OUT_TRAP  = 2'd2
  } sdbg_outcome_e;

  typedef struct packed {
    logic [3:0] coproc;
    logic [2:0] opc1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] opc2;
  } sdbg_enc_t;

  localparam sdbg_enc_t SDBG_ENC_DEFAULT = '{
    coproc: 4'b1111, opc1: 3'b000, crn: 4'b0001, crm: 4'b0001, opc2: 3'b001
  };

  // Ordered permission chain for a matched access.
  function automatic sdbg_outcome_e sdbg_judge(
    input logic [1:0] el,
    input logic       ns,
    input logic       hyp_on,
    input logic       hyp_trp,
    input logic       lock,
    input logic       wr
  );
    sdbg_outcome_e res;
    case (el)
      2'd1: begin
        if (hyp_on && hyp_trp) res = OUT_TRAP;
        else if (!ns)          res = OUT_DONE;
        else                   res = OUT_UNDEF;
      end
      2'd3: begin
        if (wr && !ns && lock) res = OUT_UNDEF;
        else                   res = OUT_DONE;
      end
      default: res = OUT_UNDEF;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sdbg_match.sv
module sdbg_match
  import sdbg_pkg::*;
#(
  parameter sdbg_enc_t ENC = SDBG_ENC_DEFAULT
) (
  input  sdbg_enc_t enc,
  output logic      hit
);
  localparam int NF = 5;
  logic [NF-1:0] fld_eq;

  always_comb begin
    fld_eq[0] = (enc.coproc == ENC.coproc);
    fld_eq[1] = (enc.opc1   == ENC.opc1);
    fld_eq[2] = (enc.crn    == ENC.crn);
    fld_eq[3] = (enc.crm    == ENC.crm);
    fld_eq[4] = (enc.opc2   == ENC.opc2);
  end

  assign hit = &fld_eq;
endmodule

// File: rtl/sdbg_gate.sv
module sdbg_gate
  import sdbg_pkg::*;
(
  input  logic [1:0]    el,
  input  logic          ns,
  input  logic          hyp_on,
  input  logic          hyp_trp,
  input  logic          lock,
  input  logic          wr,
  output sdbg_outcome_e outcome
);
  assign outcome = sdbg_judge(el, ns, hyp_on, hyp_trp, lock, wr);
endmodule

// File: rtl/sdbg_store.sv
module sdbg_store #(
  parameter int DATA_W   = 32,
  parameter int CTL_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CTL_BITS-1:0] wr_bits,
  input  logic                ns,
  output logic [CTL_BITS-1:0] ctl_q,
  output logic [DATA_W-1:0]   rd_val,
  output logic [CTL_BITS-1:0] en_out
);
  localparam int PAD_W = DATA_W - CTL_BITS;

  for (genvar i = 0; i < CTL_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctl_q[i] <= 1'b0;
      else if (wr_en) ctl_q[i] <= wr_bits[i];
    end
    assign en_out[i] = ctl_q[i] & ~ns;
  end

  assign rd_val = {{PAD_W{1'b0}}, ctl_q};
endmodule

// File: rtl/sdbg_ctl_unit.sv
module sdbg_ctl_unit
  import sdbg_pkg::*;
#(
  parameter int         DATA_W   = 32,
  parameter int         CTL_BITS = 2,
  parameter int         SYN_W    = 6,
  parameter logic [5:0] TRAP_SYN = 6'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [3:0]        req_coproc,
  input  logic [2:0]        req_opc1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_opc2,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cur_el,
  input  logic              ns_state,
  input  logic              hyp_en,
  input  logic              hyp_trap,
  input  logic              wr_lock,
  output logic              rsp_done,
  output logic              rsp_undef,
  output logic              rsp_trap,
  output logic [SYN_W-1:0]  rsp_syndrome,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              en_inv,
  output logic              en_noninv
);
  sdbg_enc_t           acc_enc;
  logic                acc_hit;
  logic                acc_fire;
  sdbg_outcome_e       acc_outcome;
  logic                wr_commit;
  logic [CTL_BITS-1:0] ctl_q;
  logic [CTL_BITS-1:0] en_vec;
  logic [DATA_W-1:0]   rd_val;
  logic                unused_wdata_hi;

  assign acc_enc = '{coproc: req_coproc, opc1: req_opc1, crn: req_crn,
                     crm: req_crm, opc2: req_opc2};

  sdbg_match u_match (
    .enc (acc_enc),
    .hit (acc_hit)
  );

  sdbg_gate u_gate (
    .el      (cur_el),
    .ns      (ns_state),
    .hyp_on  (hyp_en),
    .hyp_trp (hyp_trap),
    .lock    (wr_lock),
    .wr      (req_wr),
    .outcome (acc_outcome)
  );

  assign acc_fire  = req_vld & acc_hit;
  assign wr_commit = acc_fire & req_wr & (acc_outcome == OUT_DONE);

  sdbg_store #(.DATA_W(DATA_W), .CTL_BITS(CTL_BITS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_commit),
    .wr_bits (req_wdata[CTL_BITS-1:0]),
    .ns      (ns_state),
    .ctl_q   (ctl_q),
    .rd_val  (rd_val),
    .en_out  (en_vec)
  );

  assign unused_wdata_hi = ^req_wdata[DATA_W-1:CTL_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done     <= 1'b0;
      rsp_undef    <= 1'b0;
      rsp_trap     <= 1'b0;
      rsp_syndrome <= '0;
      rsp_rdata    <= '0;
    end else begin
      rsp_done     <= acc_fire && (acc_outcome == OUT_DONE);
      rsp_undef    <= acc_fire && (acc_outcome == OUT_UNDEF);
      rsp_trap     <= acc_fire && (acc_outcome == OUT_TRAP);
      rsp_syndrome <= (acc_fire && acc_outcome == OUT_TRAP) ? TRAP_SYN[SYN_W-1:0] : '0;
      rsp_rdata    <= (acc_fire && !req_wr && acc_outcome == OUT_DONE) ? rd_val : '0;
    end
  end

  assign en_inv    = en_vec[0];
  assign en_noninv = en_vec[1];
endmodule

// File: rtl/sdbg_ctl_chk.sv
module sdbg_ctl_chk
  import sdbg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CTL_BITS = 2,
  parameter int SYN_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_vld,
  input logic                req_wr,
  input logic [DATA_W-1:0]   req_wdata,
  input logic [1:0]          cur_el,
  input logic                ns_state,
  input logic                wr_lock,
  input logic                acc_hit,
  input logic                wr_commit,
  input logic [CTL_BITS-1:0] ctl_q,
  input logic                rsp_done,
  input logic                rsp_undef,
  input logic                rsp_trap,
  input logic [SYN_W-1:0]    rsp_syndrome,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic                en_inv,
  input logic                en_noninv
);
  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_done, rsp_undef, rsp_trap}));

  // R11
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && acc_hit) |=> ($countones({rsp_done, rsp_undef, rsp_trap}) == 1));

  // R1
  ignore_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && acc_hit) |=> !(rsp_done || rsp_undef || rsp_trap));

  // R5
  low_el_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && acc_hit && (cur_el == 2'd0 || cur_el == 2'd2)) |=> rsp_undef);

  // R6
  trap_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_syndrome == 6'h03));

  // R12
  syn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_trap |-> (rsp_syndrome == '0));

  // R12
  rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_undef || rsp_trap) |-> (rsp_rdata == '0));

  // R3
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[DATA_W-1:CTL_BITS] == '0);

  // R10
  ns_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_state |-> (!en_inv && !en_noninv));

  // R11
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (ctl_q == $past(req_wdata[CTL_BITS-1:0])));

  // R9
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && acc_hit && req_wr && cur_el == 2'd3 && !ns_state && wr_lock) |=> rsp_undef);
endmodule

bind sdbg_ctl_unit sdbg_ctl_chk #(
  .DATA_W(DATA_W), .CTL_BITS(CTL_BITS), .SYN_W(SYN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_vld      (req_vld),
  .req_wr       (req_wr),
  .req_wdata    (req_wdata),
  .cur_el       (cur_el),
  .ns_state     (ns_state),
  .wr_lock      (wr_lock),
  .acc_hit      (acc_hit),
  .wr_commit    (wr_commit),
  .ctl_q        (ctl_q),
  .rsp_done     (rsp_done),
  .rsp_undef    (rsp_undef),
  .rsp_trap     (rsp_trap),
  .rsp_syndrome (rsp_syndrome),
  .rsp_rdata    (rsp_rdata),
  .en_inv       (en_inv),
  .en_noninv    (en_noninv)
);

// File: tb/sdbg_ctl_unit_bench.sv
`timescale 1ns/1ps
module sdbg_ctl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_wr = 1'b0;
  logic [3:0]  req_coproc = '0, req_crn = '0, req_crm = '0;
  logic [2:0]  req_opc1 = '0, req_opc2 = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  cur_el = '0;
  logic        ns_state = 1'b0, hyp_en = 1'b0, hyp_trap = 1'b0, wr_lock = 1'b0;
  logic        rsp_done, rsp_undef, rsp_trap, en_inv, en_noninv;
  logic [5:0]  rsp_syndrome;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;
  logic [1:0] model_bits = 2'b00;

  always #4 clk = ~clk;

  sdbg_ctl_unit u_sdbg_ctl_unit (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // 0 = completes, 1 = undefined, 2 = trapped
  function automatic int expect_result(input logic [1:0] el, input logic ns, input logic he,
                                       input logic ht, input logic lk, input logic wr);
    if (el == 2'd0 || el == 2'd2) return 1;
    if (el == 2'd3) return (wr && lk && !ns) ? 1 : 0;
    if (he && ht) return 2;
    return ns ? 1 : 0;
  endfunction

  function automatic string result_tag(input logic [1:0] el, input logic wr);
    if (el == 2'd1) return "R6/R7";
    if (el == 2'd3) return wr ? "R9" : "R8";
    return "R5";
  endfunction

  task automatic access(input bit match, input logic wr, input logic [31:0] wd, input logic [1:0] el,
                        input logic ns, input logic he, input logic ht, input logic lk);
    int res;
    logic [2:0] exp_str;
    logic [31:0] exp_rd;
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_wdata = wd;
    cur_el = el; ns_state = ns; hyp_en = he; hyp_trap = ht; wr_lock = lk;
    if (match) begin
      req_coproc = 4'b1111; req_opc1 = 3'b000; req_crn = 4'b0001; req_crm = 4'b0001; req_opc2 = 3'b001;
    end else begin
      req_coproc = 4'b1111; req_opc1 = 3'b000; req_crn = 4'b0001; req_crm = 4'b0001; req_opc2 = 3'b001;
      case ($urandom_range(0, 4))
        0: req_coproc = 4'($urandom_range(0, 14));
        1: req_opc1 = 3'($urandom_range(1, 7));
        2: req_crn = 4'($urandom_range(2, 15));
        3: req_crm = 4'($urandom_range(2, 15));
        default: req_opc2 = 3'($urandom_range(2, 7));
      endcase
    end
    res = match ? expect_result(el, ns, he, ht, lk, wr) : -1;
    exp_str = (res == 0) ? 3'b100 : (res == 1) ? 3'b010 : (res == 2) ? 3'b001 : 3'b000;
    exp_rd = (res == 0 && !wr) ? {30'd0, model_bits} : 32'd0;
    if (res == 0 && wr) model_bits = wd[1:0];
    @(negedge clk);
    req_vld = 1'b0;
    check({rsp_done, rsp_undef, rsp_trap} == exp_str,
          match ? {result_tag(el, wr), " R11 strobes"} : "R1 ignored strobes",
          {29'd0, rsp_done, rsp_undef, rsp_trap}, {29'd0, exp_str});
    check(rsp_rdata == exp_rd, "R12 rdata", rsp_rdata, exp_rd);
    check(rsp_rdata[31:2] == 30'd0, "R3 reserved read bits", rsp_rdata, exp_rd);
    check(rsp_syndrome == ((res == 2) ? 6'h03 : 6'h00), "R6 syndrome",
          {26'd0, rsp_syndrome}, (res == 2) ? 32'h3 : 32'h0);
    check({en_noninv, en_inv} == (ns ? 2'b00 : model_bits), ns ? "R10 enables gated" : "R2 enables",
          {30'd0, en_noninv, en_inv}, {30'd0, ns ? 2'b00 : model_bits});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R4 reset state
    check({rsp_done, rsp_undef, rsp_trap, en_inv, en_noninv} == 5'b0, "R4 strobes/enables in reset",
          {27'd0, rsp_done, rsp_undef, rsp_trap, en_inv, en_noninv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_rdata == 32'd0 && rsp_syndrome == 6'd0, "R4 data after reset", rsp_rdata, 32'd0);
    access(1, 0, 32'h0, 2'd3, 0, 0, 0, 0);                 // R4 read back zero
    access(1, 1, 32'hFFFF_FFFF, 2'd3, 0, 0, 0, 0);         // R3 R9 write completes
    access(1, 0, 32'h0, 2'd3, 0, 0, 0, 1);                 // R8 read with lock
    // R11 strobes clear one cycle later
    @(negedge clk);
    check({rsp_done, rsp_undef, rsp_trap} == 3'b000, "R11 single-cycle strobe",
          {29'd0, rsp_done, rsp_undef, rsp_trap}, 32'd0);
    access(1, 0, 32'h0, 2'd3, 1, 0, 0, 0);                 // R10 enables gated
    access(1, 1, 32'h0000_0001, 2'd3, 0, 0, 0, 1);         // R9 locked
    access(1, 1, 32'h0000_0001, 2'd3, 1, 0, 0, 1);         // R9 non-secure ignores lock
    access(1, 1, 32'h0000_0002, 2'd1, 0, 1, 1, 0);         // R6 trap
    access(1, 1, 32'h0000_0002, 2'd1, 1, 1, 1, 0);         // R6 over security
    access(1, 1, 32'h0000_0002, 2'd1, 0, 1, 0, 0);         // R7 completes
    access(1, 0, 32'h0, 2'd1, 1, 0, 1, 0);                 // R7 undefined
    access(1, 1, 32'h0000_0003, 2'd0, 0, 0, 0, 0);         // R5 level 0
    access(1, 0, 32'h0, 2'd2, 0, 0, 0, 0);                 // R5 level 2
    access(0, 1, 32'h0000_0001, 2'd3, 0, 0, 0, 0);         // R1 mismatch write
    access(1, 0, 32'h0, 2'd3, 0, 0, 0, 0);                 // R1 state kept
    for (int i = 0; i < 400; i++) begin
      access($urandom_range(0, 3) != 0, 1'($urandom), $urandom, 2'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    ended = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule